// File: doc/BRIEF.md
# Oversampled SPI Slave Byte Engine

This block is the target side of a serial peripheral interface. It runs entirely on the system clock. The serial clock, the data input from the master and the active-low select come in from outside. Each of them passes through a two-stage synchronizer. Serial clock edges are then found by comparing successive synchronized samples, so the serial clock is never used as a clock. The master sets the bit rate. That rate may be anything up to one eighth of the system clock.

Two configuration inputs set the transfer mode: a phase bit and a polarity bit. Characters are 8 bits wide and travel most significant bit first. The host side has the following:
- a one-deep transmit buffer with an empty flag;
- a receive register with a not-empty flag and a read strobe;
- a sticky overrun flag with a clear strobe.

The master-input line is driven only while the block is selected.

Top module: `spi_sync_slave`

## Requirements
- R1: After reset, tx_empty_o is 1, rx_full_o is 0, overrun_o is 0 and miso_oe_o is 0.
- R2: When cfg_phase equals cfg_cpol, data is launched on falling serial clock edges and sampled on rising ones. When they differ, data is launched on rising edges and sampled on falling ones. Characters are 8 bits, most significant bit first, in both directions.
- R3: When the 8th bit of a character is sampled and rx_full_o is 0, the byte appears on rx_data_o and rx_full_o becomes 1. A one-cycle rx_rd_i pulse clears rx_full_o.
- R4: A tx_wr_i pulse stores tx_data_i and clears tx_empty_o. When a character starts, the stored byte moves into the shifter and tx_empty_o returns to 1.
- R5: If tx_empty_o is 1 when a character starts, the character sent is 0xFF.
- R6: If a character completes while rx_full_o is 1 and no read is given, overrun_o becomes 1 and rx_data_o keeps the older byte. An ovr_clr_i pulse clears overrun_o.
- R7: With cfg_phase = 0, the first bit of a character is on miso_o once select is asserted, before any serial clock edge. The next character is loaded as soon as the 8th bit is sampled.
- R8: Releasing select in the middle of a character discards the bits received so far and restarts the bit count. No byte is delivered from the aborted character.
- R9: miso_oe_o is 1 while select is asserted and 0 while it is released.
- R10: Transfers work at a serial clock of one eighth of the system clock, in all four modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_phase | input | 1 | Phase select; 0 means the first bit is ready at select |
| cfg_cpol | input | 1 | Serial clock idle level |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low select from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for miso_o |
| tx_data_i | input | 8 | Byte to transmit |
| tx_wr_i | input | 1 | Write strobe for tx_data_i |
| tx_empty_o | output | 1 | Transmit buffer is empty |
| rx_data_o | output | 8 | Last delivered received byte |
| rx_rd_i | input | 1 | Read strobe, clears rx_full_o |
| rx_full_o | output | 1 | A received byte is waiting |
| overrun_o | output | 1 | A character arrived while rx_full_o was set |
| ovr_clr_i | input | 1 | Clears overrun_o |

## Verification
Every one of the four phase/polarity combinations carries two back-to-back characters at one eighth of the system clock. The first character carries a written byte. The second finds the buffer empty, which separates correct edge mapping and load timing (R2, R4) from the 0xFF fill (R5). The transmitted bytes differ in their top bit, so the phase-0 check of miso_o before any serial clock edge sees both levels.

Two further patterns target the receive side. Two characters arrive with no read in between, which separates overrun handling from plain delivery. A character is cut off after three bits and followed by a full one, which shows whether partial bits leak into the next byte.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef struct packed {
    logic launch;
    logic sample;
  } sck_evt_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int                 W       = 1,
  parameter int                 STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
  import spi_slv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_s,
  input  logic     phase,
  input  logic     cpol,
  output sck_evt_t evt
);
  logic sck_d;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  always_comb begin
    rise = sck_s & ~sck_d;
    fall = ~sck_s & sck_d;
    if (phase == cpol) begin
      evt.launch = fall;
      evt.sample = rise;
    end else begin
      evt.launch = rise;
      evt.sample = fall;
    end
  end

  // R2: one serial clock edge is either a launch or a sample, never both
  p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt.launch, evt.sample}));
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
#(
  parameter int BITS = 8,
  localparam int CW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_s,
  input  logic            mosi_s,
  input  logic            phase,
  input  sck_evt_t        evt,
  input  logic [BITS-1:0] load_byte,
  output logic            load,
  output logic            complete,
  output logic [BITS-1:0] rx_byte,
  output logic            miso
);
  logic [CW-1:0]   cnt, cnt_n;
  logic [BITS-1:0] txsh, txsh_n;
  logic [BITS-1:0] rxsh, rxsh_n;
  logic            sel_d;
  logic            sel_rise;

  assign sel_rise = sel_s & ~sel_d;

  always_comb begin
    cnt_n    = cnt;
    txsh_n   = txsh;
    rxsh_n   = rxsh;
    load     = 1'b0;
    complete = 1'b0;
    if (!sel_s) begin
      cnt_n = '0;
    end else begin
      if (evt.sample) begin
        rxsh_n = {rxsh[BITS-2:0], mosi_s};
        if (cnt == CW'(BITS-1)) begin
          complete = 1'b1;
          cnt_n    = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      if (evt.launch) begin
        if (cnt != '0)  txsh_n = {txsh[BITS-2:0], 1'b1};
        else if (phase) load   = 1'b1;
      end
      if (!phase && (sel_rise || complete)) load = 1'b1;
      if (load) txsh_n = load_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      txsh  <= '1;
      rxsh  <= '0;
      sel_d <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      txsh  <= txsh_n;
      rxsh  <= rxsh_n;
      sel_d <= sel_s;
    end
  end

  assign rx_byte = rxsh_n;
  assign miso    = txsh[BITS-1];

  // R8: a released select leaves the bit count at zero
  p_abort_clears_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_s && $past(!sel_s)) |-> (cnt == '0));
  // R7: in phase 0 a new select always loads the shifter
  p_phase0_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && !phase) |-> load);
endmodule

// File: rtl/spi_sync_slave.sv
module spi_sync_slave
  import spi_slv_pkg::*;
#(
  parameter int BITS      = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_phase,
  input  logic            cfg_cpol,
  input  logic            sck_i,
  input  logic            mosi_i,
  input  logic            ss_n_i,
  output logic            miso_o,
  output logic            miso_oe_o,
  input  logic [BITS-1:0] tx_data_i,
  input  logic            tx_wr_i,
  output logic            tx_empty_o,
  output logic [BITS-1:0] rx_data_o,
  input  logic            rx_rd_i,
  output logic            rx_full_o,
  output logic            overrun_o,
  input  logic            ovr_clr_i
);
  logic [2:0]      pins_s;
  logic            sck_s, mosi_s, sel_s;
  sck_evt_t        evt;
  logic            load, complete;
  logic [BITS-1:0] rx_byte, load_byte;
  logic [BITS-1:0] tx_buf, tx_buf_n, rx_data_n;
  logic            tx_empty_n, rx_full_n, ovr_n;

  spi_slv_sync #(.W(3), .STAGES(SYNC_STGS), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({ss_n_i, mosi_i, sck_i}),
    .q_o(pins_s)
  );

  assign sck_s  = pins_s[0];
  assign mosi_s = pins_s[1];
  assign sel_s  = ~pins_s[2];

  spi_slv_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s),
    .phase(cfg_phase), .cpol(cfg_cpol), .evt(evt)
  );

  assign load_byte = tx_empty_o ? '1 : tx_buf;

  spi_slv_shift #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .mosi_s(mosi_s),
    .phase(cfg_phase), .evt(evt), .load_byte(load_byte),
    .load(load), .complete(complete), .rx_byte(rx_byte), .miso(miso_o)
  );

  assign miso_oe_o = sel_s;

  always_comb begin
    tx_buf_n   = tx_buf;
    tx_empty_n = tx_empty_o;
    rx_data_n  = rx_data_o;
    rx_full_n  = rx_full_o;
    ovr_n      = overrun_o;
    if (load) tx_empty_n = 1'b1;
    if (tx_wr_i) begin
      tx_buf_n   = tx_data_i;
      tx_empty_n = 1'b0;
    end
    if (rx_rd_i)   rx_full_n = 1'b0;
    if (ovr_clr_i) ovr_n     = 1'b0;
    if (complete) begin
      if (rx_full_o && !rx_rd_i) begin
        ovr_n = 1'b1;
      end else begin
        rx_data_n = rx_byte;
        rx_full_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf     <= '0;
      tx_empty_o <= 1'b1;
      rx_data_o  <= '0;
      rx_full_o  <= 1'b0;
      overrun_o  <= 1'b0;
    end else begin
      tx_buf     <= tx_buf_n;
      tx_empty_o <= tx_empty_n;
      rx_data_o  <= rx_data_n;
      rx_full_o  <= rx_full_n;
      overrun_o  <= ovr_n;
    end
  end

  p_rx_flag_on_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !rx_full_o) |=> rx_full_o);
  p_load_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !tx_wr_i) |=> tx_empty_o);
  p_ovr_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && rx_full_o && !rx_rd_i) |=> (overrun_o && $stable(rx_data_o)));
  p_no_tx_while_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe_o |-> !complete);
endmodule

// File: tb/spi_sync_slave_bench.sv
module spi_sync_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_phase = 1'b0, cfg_cpol = 1'b0;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic       miso_o, miso_oe_o;
  logic [7:0] tx_data_i = '0;
  logic       tx_wr_i = 1'b0;
  logic       tx_empty_o;
  logic [7:0] rx_data_o;
  logic       rx_rd_i = 1'b0;
  logic       rx_full_o, overrun_o;
  logic       ovr_clr_i = 1'b0;

  int   checks = 0, errors = 0;
  bit   auto_rd = 1'b1;
  bit   done = 1'b0;
  logic [7:0] exp_q [$];

  spi_sync_slave u_spi_sync_slave (.*);

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: pops expected bytes as the slave delivers them
  always @(negedge clk) begin
    if (rx_rd_i) rx_rd_i <= 1'b0;
    else if (auto_rd && rx_full_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", rx_data_o, 0);
      else chk(rx_data_o == exp_q[0], "R3 rx byte", rx_data_o, exp_q[0]);
      if (exp_q.size() != 0) void'(exp_q.pop_front());
      rx_rd_i <= 1'b1;
    end
  end

  task automatic sel_on();
    ss_n_i = 1'b0;
    tick(2*HALF);
  endtask

  task automatic sel_off();
    tick(HALF);
    ss_n_i = 1'b1;
    tick(2*HALF);
  endtask

  task automatic write_tx(input logic [7:0] b);
    tx_data_i = b; tx_wr_i = 1'b1;
    tick(1);
    tx_wr_i = 1'b0;
  endtask

  // master model, serial clock = system clock / 8 (R10)
  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi, input bit push);
    if (push) exp_q.push_back(mo);
    mi = '0;
    if (!cfg_phase) begin
      mosi_i = mo[7];
      for (int i = 7; i >= 0; i--) begin
        tick(HALF); sck_i = ~sck_i; mi = {mi[6:0], miso_o};
        tick(HALF); sck_i = ~sck_i;
        if (i > 0) mosi_i = mo[i-1];
      end
    end else begin
      for (int i = 7; i >= 0; i--) begin
        tick(HALF); sck_i = ~sck_i; mosi_i = mo[i];
        tick(HALF); sck_i = ~sck_i; mi = {mi[6:0], miso_o};
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R10 watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi;
    logic [7:0] pat [4] = '{8'hA6, 8'h4D, 8'hF0, 8'h1B};
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk(tx_empty_o == 1'b1, "R1 tx_empty", tx_empty_o, 1);
    chk(rx_full_o == 1'b0, "R1 rx_full", rx_full_o, 0);
    chk(overrun_o == 1'b0, "R1 overrun", overrun_o, 0);
    chk(miso_oe_o == 1'b0, "R1 miso_oe", miso_oe_o, 0);

    for (int m = 0; m < 4; m++) begin
      cfg_phase = m[1]; cfg_cpol = m[0]; sck_i = m[0];
      tick(6);
      write_tx(pat[m]);
      chk(tx_empty_o == 1'b0, "R4 buffer full", tx_empty_o, 0);
      sel_on();
      chk(miso_oe_o == 1'b1, "R9 oe selected", miso_oe_o, 1);
      if (!cfg_phase) begin
        chk(miso_o == pat[m][7], "R7 first bit early", miso_o, pat[m][7]);
        chk(tx_empty_o == 1'b1, "R4 load at select", tx_empty_o, 1);
      end
      xfer(8'h35 + 8'(m), mi, 1'b1);
      chk(mi == pat[m], "R2/R10 tx byte", mi, pat[m]);
      chk(tx_empty_o == 1'b1, "R4 buffer drained", tx_empty_o, 1);
      xfer(8'hC8 - 8'(m), mi, 1'b1);
      chk(mi == 8'hFF, "R5 empty fill", mi, 8'hFF);
      sel_off();
      chk(miso_oe_o == 1'b0, "R9 oe released", miso_oe_o, 0);
      tick(6);
      chk(exp_q.size() == 0, "R3 all delivered", exp_q.size(), 0);
    end

    // R6 overrun: two characters, no read
    cfg_phase = 1'b0; cfg_cpol = 1'b0; sck_i = 1'b0;
    tick(6);
    auto_rd = 1'b0;
    sel_on();
    xfer(8'h3C, mi, 1'b1);
    xfer(8'hA5, mi, 1'b0);
    sel_off();
    chk(overrun_o == 1'b1, "R6 overrun set", overrun_o, 1);
    chk(rx_data_o == 8'h3C, "R6 old byte kept", rx_data_o, 8'h3C);
    auto_rd = 1'b1;
    tick(6);
    chk(exp_q.size() == 0, "R3 read after overrun", exp_q.size(), 0);
    ovr_clr_i = 1'b1; tick(1); ovr_clr_i = 1'b0; tick(1);
    chk(overrun_o == 1'b0, "R6 overrun cleared", overrun_o, 0);

    // R8 abort after three bits, then a clean character
    sel_on();
    for (int i = 0; i < 3; i++) begin
      mosi_i = 1'b1;
      tick(HALF); sck_i = ~sck_i;
      tick(HALF); sck_i = ~sck_i;
    end
    sel_off();
    chk(rx_full_o == 1'b0, "R8 no byte from abort", rx_full_o, 0);
    sel_on();
    xfer(8'h96, mi, 1'b1);
    sel_off();
    tick(6);
    chk(exp_q.size() == 0, "R8 clean byte after abort", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule